// File: doc/BRIEF.md
# Fourth-Order One-Bit Noise Shaper

This block turns an oversampled multi-bit audio stream for one channel into a one-bit stream whose quantization noise is pushed out of the audio band. It is a chain of four integrators with distributed feedback. Every coefficient is a power of two, so each one is an arithmetic shift. The quantizer is the sign of the last integrator. Its bit picks the sign of a feedback reference that every stage subtracts: plus the reference for a 1 and minus the reference for a 0.

A base tick `tickEn` drives the loop. The rate mode input sets how many ticks make one loop step: two in base-rate mode, which gives 128 bits per input sample with a 256× tick, and four in high-rate mode, which gives 64 per sample. The signed input is sampled at each step and must be held by the caller in between. Every accumulator saturates and has guard bits. When any integrator stays on a rail for a run of consecutive steps, the loop is judged unstable. All integrators are then cleared and an overload flag is raised for one step.

Top module: `ns4_modulator`

## Requirements
- R1: Each loop step yields exactly one single-cycle `bitValid` pulse, and `bitOut` holds that step's bit from the pulse until the next step.
- R2: With `highRate` low, one step occurs for every 2 cycles in which `tickEn` is high.
- R3: With `highRate` high, one step occurs for every 4 cycles in which `tickEn` is high.
- R4: A cycle with `tickEn` low never produces a step, so `bitValid` stays low in the following cycle.
- R5: During and after reset `bitOut`, `bitValid` and `overload` are 0 and all integrators are zero. With zero input, the first two bits are 1 then 0. The quantizer gives 1 when the last integrator is at least zero, and a 1 subtracts the positive reference.
- R6: With zero input, the share of ones over 2048 bits is 0.5 within ±64 bits.
- R7: For a DC input u with |u| ≤ REF/2, where REF = 2^(IN_W-2), the share of ones over 2048 bits is (1 + u/REF)/2 within ±64 bits, and `overload` stays low.
- R8: Integrators clamp at their rails instead of wrapping. An input above REF drives them into saturation. After 16 consecutive steps with some integrator on a rail, `overload` rises together with that step's `bitValid` and stays high for exactly one step.
- R9: The step that raises `overload` clears all four integrators, so the next two bits are 1 then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Base tick enable; steps are derived from it |
| highRate | input | 1 | 0: step every 2 ticks, 1: step every 4 ticks |
| sampleIn | input | IN_W | Signed input sample, held between steps |
| bitOut | output | 1 | Quantized bit of the latest step |
| bitValid | output | 1 | One-cycle pulse after each step |
| overload | output | 1 | High for one step after an instability clear |

## Verification
The hardest state to reach from the ports is the instability clear. A correct loop with in-range input never keeps an integrator on a rail for 16 steps. The bench therefore holds the input at its positive maximum, about twice the feedback reference, so the integrators run away polynomially and pin the last stage at its rail. It then watches for the overload pulse and checks that the following two bits show the fresh-from-zero pattern 1, 0. This proves the clear reached every integrator.

// File: rtl/ns4_pkg.sv
package ns4_pkg;
  localparam int ORDER = 4;

  typedef struct packed {
    logic step;
    logic clear;
  } strobe_t;
endpackage

// File: rtl/ns4_integ.sv
module ns4_integ #(
  parameter int ACC_W = 20,
  parameter int SW    = 22
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stepEn,
  input  logic                    clrEn,
  input  logic signed [SW-1:0]    termIn,
  output logic signed [ACC_W-1:0] acc,
  output logic                    sat
);
  localparam logic signed [SW-1:0] HI = SW'((2 ** (ACC_W - 1)) - 1);
  localparam logic signed [SW-1:0] LO = -HI - SW'(1);

  logic signed [SW-1:0]    sum;
  logic signed [ACC_W-1:0] nextAcc;

  assign sum = SW'(acc) + termIn;

  always_comb begin
    if (sum > HI)      nextAcc = HI[ACC_W-1:0];
    else if (sum < LO) nextAcc = LO[ACC_W-1:0];
    else               nextAcc = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      acc <= '0;
    else if (stepEn) acc <= clrEn ? '0 : nextAcc;
  end

  assign sat = (SW'(acc) == HI) || (SW'(acc) == LO);
endmodule

// File: rtl/ns4_datapath.sv
module ns4_datapath import ns4_pkg::*; #(
  parameter int IN_W  = 16,
  parameter int GUARD = 4,
  parameter int SH1   = 10,
  parameter int SH2   = 7,
  parameter int SH3   = 4,
  parameter int SH4   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  strobe_t                strobes,
  input  logic signed [IN_W-1:0] sampleIn,
  output logic                   bitOut,
  output logic                   bitValid,
  output logic                   anySat,
  output logic                   allZero
);
  localparam int ACC_W = IN_W + GUARD;
  localparam int SW    = ACC_W + 2;
  localparam logic signed [SW-1:0] REF_W = SW'(2 ** (IN_W - 2));
  localparam int SHV [ORDER] = '{SH1, SH2, SH3, SH4};

  logic signed [ACC_W-1:0] acc  [ORDER];
  logic signed [SW-1:0]    term [ORDER];
  logic [ORDER-1:0]        satV;
  logic                    decision;
  logic signed [SW-1:0]    fbW;

  // Quantizer: sign of the last integrator
  assign decision = ~acc[ORDER-1][ACC_W-1];
  assign fbW      = decision ? REF_W : -REF_W;

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign term[k] = (SW'(sampleIn) - fbW) >>> SHV[k];
    end else begin : g_rest
      assign term[k] = SW'(acc[k-1]) - (fbW >>> SHV[k]);
    end

    ns4_integ #(.ACC_W(ACC_W), .SW(SW)) u_integ (
      .clk    (clk),
      .rst_n  (rst_n),
      .stepEn (strobes.step),
      .clrEn  (strobes.clear),
      .termIn (term[k]),
      .acc    (acc[k]),
      .sat    (satV[k])
    );
  end

  assign anySat = |satV;

  always_comb begin
    allZero = 1'b1;
    for (int k = 0; k < ORDER; k++)
      if (acc[k] != '0) allZero = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitOut   <= 1'b0;
      bitValid <= 1'b0;
    end else begin
      bitValid <= strobes.step;
      if (strobes.step) bitOut <= decision;
    end
  end
endmodule

// File: rtl/ns4_ctrl.sv
module ns4_ctrl import ns4_pkg::*; #(
  parameter int OVL_LIMIT = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tickEn,
  input  logic    highRate,
  input  logic    anySat,
  output strobe_t strobes,
  output logic    overload
);
  localparam int CW = $clog2(OVL_LIMIT + 1);

  logic [1:0]    divCnt;
  logic [1:0]    divMax;
  logic [CW-1:0] satCnt;
  logic          stepNow;
  logic          clearNow;

  assign divMax   = highRate ? 2'd3 : 2'd1;
  assign stepNow  = tickEn && (divCnt >= divMax);
  assign clearNow = stepNow && anySat && (satCnt == CW'(OVL_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divCnt   <= '0;
      satCnt   <= '0;
      overload <= 1'b0;
    end else begin
      if (tickEn) divCnt <= stepNow ? 2'd0 : divCnt + 2'd1;
      if (stepNow) begin
        satCnt   <= (clearNow || !anySat) ? '0 : satCnt + CW'(1);
        overload <= clearNow;
      end
    end
  end

  assign strobes.step  = stepNow;
  assign strobes.clear = clearNow;

  // R8: overload lasts one step only
  p_ovl_one_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stepNow && overload) |=> !overload);
endmodule

// File: rtl/ns4_modulator.sv
module ns4_modulator import ns4_pkg::*; #(
  parameter int IN_W      = 16,
  parameter int GUARD     = 4,
  parameter int OVL_LIMIT = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tickEn,
  input  logic                   highRate,
  input  logic signed [IN_W-1:0] sampleIn,
  output logic                   bitOut,
  output logic                   bitValid,
  output logic                   overload
);
  strobe_t strobes;
  logic    anySat;
  logic    allZero;

  ns4_ctrl #(.OVL_LIMIT(OVL_LIMIT)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tickEn   (tickEn),
    .highRate (highRate),
    .anySat   (anySat),
    .strobes  (strobes),
    .overload (overload)
  );

  ns4_datapath #(.IN_W(IN_W), .GUARD(GUARD)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .sampleIn (sampleIn),
    .bitOut   (bitOut),
    .bitValid (bitValid),
    .anySat   (anySat),
    .allZero  (allZero)
  );

  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bitValid |=> !bitValid);

  p_no_tick_no_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tickEn |=> !bitValid);

  p_ovl_with_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overload) |-> bitValid);

  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overload) |-> allZero);
endmodule

// File: tb/ns4_modulator_tb.sv
module ns4_modulator_tb;
  localparam int IN_W = 16;
  localparam int REF  = 2 ** (IN_W - 2);

  logic clk = 1'b0;
  logic rst_n;
  logic tickEn;
  logic highRate;
  logic signed [IN_W-1:0] sampleIn;
  logic bitOut, bitValid, overload;

  int nChecks = 0;
  int nFails  = 0;
  logic bitLog [0:599];
  logic ovlLog [0:599];

  always #10 clk = ~clk;

  ns4_modulator #(.IN_W(IN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .highRate(highRate),
    .sampleIn(sampleIn), .bitOut(bitOut), .bitValid(bitValid), .overload(overload)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tickEn = 1'b0; highRate = 1'b0; sampleIn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Collect n bits; logs up to 600 entries
  task automatic grab(input int n, output int ones, output int ovls);
    int got = 0;
    ones = 0; ovls = 0;
    while (got < n) begin
      @(negedge clk);
      if (bitValid) begin
        if (got < 600) begin bitLog[got] = bitOut; ovlLog[got] = overload; end
        ones += int'(bitOut);
        ovls += int'(overload);
        got++;
      end
    end
  endtask

  task automatic count_valid(input int cycles, input bit halfTick, output int cnt);
    cnt = 0;
    for (int c = 0; c < cycles; c++) begin
      tickEn = halfTick ? c[0] : 1'b1;
      @(negedge clk);
      cnt += int'(bitValid);
    end
  endtask

  task automatic t_reset_state();
    int ones, ovls;
    rst_n = 1'b0; tickEn = 1'b1; highRate = 1'b0; sampleIn = '0;
    repeat (3) @(negedge clk);
    check(bitOut == 1'b0,   "R5", int'(bitOut), 0);
    check(bitValid == 1'b0, "R5", int'(bitValid), 0);
    check(overload == 1'b0, "R5", int'(overload), 0);
    rst_n = 1'b1;
    grab(2, ones, ovls);
    check(bitLog[0] == 1'b1, "R5", int'(bitLog[0]), 1);
    check(bitLog[1] == 1'b0, "R5", int'(bitLog[1]), 0);
  endtask

  task automatic t_rates();
    int cnt;
    do_reset();
    tickEn = 1'b1;
    repeat (8) @(negedge clk);
    count_valid(40, 1'b0, cnt);
    check(cnt == 20, "R2", cnt, 20);
    count_valid(40, 1'b1, cnt);
    check(cnt == 10, "R2", cnt, 10);
    highRate = 1'b1;
    repeat (8) @(negedge clk);
    count_valid(40, 1'b0, cnt);
    check(cnt == 10, "R3", cnt, 10);
    count_valid(80, 1'b1, cnt);
    check(cnt == 10, "R3", cnt, 10);
  endtask

  task automatic t_no_tick();
    int cnt = 0;
    do_reset();
    tickEn = 1'b0;
    @(negedge clk);
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      cnt += int'(bitValid);
    end
    check(cnt == 0, "R4", cnt, 0);
  endtask

  task automatic t_dc(input int u, input string req);
    int ones, ovls, expOnes, diff;
    do_reset();
    sampleIn = IN_W'(u);
    tickEn = 1'b1;
    grab(256, ones, ovls);
    grab(2048, ones, ovls);
    expOnes = (2048 * (REF + u)) / (2 * REF);
    diff = ones - expOnes;
    check(diff <= 64 && diff >= -64, req, ones, expOnes);
    check(ovls == 0, req, ovls, 0);
  endtask

  task automatic t_overload();
    int ones, ovls, idx;
    do_reset();
    sampleIn = IN_W'(2 ** (IN_W - 1) - 1);
    tickEn = 1'b1;
    grab(600, ones, ovls);
    idx = -1;
    for (int i = 0; i < 597; i++)
      if (idx < 0 && ovlLog[i]) idx = i;
    check(idx >= 0, "R8", idx, 0);
    if (idx >= 0) begin
      check(ovlLog[idx+1] == 1'b0, "R8", int'(ovlLog[idx+1]), 0);
      check(bitLog[idx+1] == 1'b1, "R9", int'(bitLog[idx+1]), 1);
      check(bitLog[idx+2] == 1'b0, "R9", int'(bitLog[idx+2]), 0);
    end
  endtask

  task automatic t_pulse_hold();
    int hi = 0;
    logic held;
    do_reset();
    highRate = 1'b1; tickEn = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (bitValid) begin
        held = bitOut;
        @(negedge clk);
        hi += int'(bitValid);
        check(bitOut == held, "R1", int'(bitOut), int'(held));
      end
    end
    check(hi == 0, "R1", hi, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_rates();
    t_no_tick();
    t_pulse_hold();
    t_dc(0, "R6");
    t_dc(REF / 4, "R7");
    t_dc(-REF / 2, "R7");
    t_overload();
    finish_run();
  end
endmodule